// File: doc/BRIEF.md
# SPI FIFO Event and Interrupt Unit

This block holds the transmit and receive byte FIFOs of an SPI controller, together with the mode, event and mask registers around them. Software reaches everything through a simple 32-bit register port. It pushes 1, 2 or 4 bytes into the transmit FIFO per write and pops 1, 2 or 4 bytes from the receive FIFO per read. Multi-byte data is right-justified on the bus, and the first byte on the wire sits in the most significant position.

The serial shifter sits outside the block and connects through a byte-wide handshake. On one side it takes transmit bytes, and on the other it offers received bytes along with a transfer-done pulse. Occupancy is reported as byte counts. A set of sticky status flags is cleared by writing ones, and each flag can be routed to a single registered interrupt line through a mask. A loopback mode moves transmit bytes straight into the receive FIFO. Clearing the enable bit empties both FIFOs.

Top module: `spi_fifo_event_unit`

## Requirements
- R1: After reset the mode register reads 0x0000040F (enable bit 31 = 0, loopback bit 30 = 0, transmit threshold bits 13:8 = 4, receive threshold bits 5:0 = 15), both FIFOs are empty, and irq is 0.
- R2: Register offsets on bus_addr are: mode 0x00, events 0x04, mask 0x08, transmit data 0x10, receive data 0x14. bus_size selects 1 byte (0), 2 bytes (1) or 4 bytes (2 or 3) for the data offsets. Accesses to mode, events and mask are always full 32-bit.
- R3: A transmit write of n bytes queues bus_wdata[8n-1:0] most significant byte first and reduces the free count by n. A write is dropped whole when the free space is below n or the block is disabled.
- R4: A receive read of n bytes returns the next n bytes right-justified in bus_rdata on the cycle after the request, with the oldest byte most significant, and reduces the count by n. If fewer than n bytes are held, the read returns zero and the count is unchanged.
- R5: sh_tx_valid is high when the block is enabled, not in loopback, and the transmit FIFO is not empty. sh_tx_data shows the oldest byte, which leaves on sh_tx_take. An sh_rx_push byte is stored only when the block is enabled, not in loopback, and the receive FIFO is not full; otherwise it is lost.
- R6: The event register reads the receive byte count in bits 29:24 and the transmit free-space count in bits 21:16 (32 when empty). Its flags are: 15 transmit empty, 14 done, 13 receive threshold, 12 receive full, 11 transmit threshold, 9 receive not empty, 8 transmit not full.
- R7: A flag sets whenever its condition holds and stays set after the condition ends. The done flag sets on an sh_done pulse.
- R8: Writing the event register clears every flag whose data bit is 1. A flag whose condition still holds sets again.
- R9: irq goes high one cycle after any flag is set while its mask bit (same position in the mask register) is 1, and stays low otherwise.
- R10: The receive-threshold condition is count > receive threshold. The transmit-threshold condition is free space > transmit threshold. Equality does not set either flag.
- R11: In loopback with the block enabled, one byte per cycle moves from the transmit FIFO to the receive FIFO while the receive FIFO has room. The shifter handshake is idle during this.
- R12: While the enable bit is 0, both FIFOs are held empty: the free count reads 32 and the receive count reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_size | input | 2 | Data access size code |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| sh_tx_valid | output | 1 | Transmit byte available to the shifter |
| sh_tx_data | output | 8 | Oldest transmit byte |
| sh_tx_take | input | 1 | Shifter consumes the transmit byte |
| sh_rx_push | input | 1 | Shifter offers a received byte |
| sh_rx_data | input | 8 | Received byte |
| sh_done | input | 1 | Transfer-done pulse from the shifter |
| irq | output | 1 | Registered interrupt request |

## Verification
Random mixes of 1-, 2- and 4-byte transmit writes, drained through the shifter side, show whether byte ordering and wrap-around across the four storage banks hold at every pointer alignment. Random receive reads of mixed sizes against bytes pushed by the shifter separate a correct pop count from an off-by-one lane selection, and the underfill read checks the zero-return rule. Directed fills to exactly the threshold and one past it tell strict from non-strict comparison. The sticky-flag, write-one-clear and masked-interrupt sequences, loopback and the disable flush each check one control path on its own.

// File: rtl/spi_fev_pkg.sv
package spi_fev_pkg;
  // Event flag positions (shared by event and mask registers)
  localparam int FLG_TXE = 15;
  localparam int FLG_DON = 14;
  localparam int FLG_RXT = 13;
  localparam int FLG_RXF = 12;
  localparam int FLG_TXT = 11;
  localparam int FLG_RNE = 9;
  localparam int FLG_TNF = 8;
  localparam logic [15:0] FLG_VALID = 16'hFB00;

  // Register offsets
  localparam logic [4:0] OFS_MODE = 5'h00;
  localparam logic [4:0] OFS_EVT  = 5'h04;
  localparam logic [4:0] OFS_MASK = 5'h08;
  localparam logic [4:0] OFS_TXD  = 5'h10;
  localparam logic [4:0] OFS_RXD  = 5'h14;

  typedef enum logic [1:0] {
    ACC_BYTE = 2'd0,
    ACC_HALF = 2'd1,
    ACC_WORD = 2'd2
  } acc_size_e;

  function automatic logic [2:0] acc_bytes(input logic [1:0] code);
    case (code)
      ACC_BYTE: acc_bytes = 3'd1;
      ACC_HALF: acc_bytes = 3'd2;
      default:  acc_bytes = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/sfe_byte_fifo.sv
// Byte FIFO stored as LANES byte-wide banks so that up to LANES consecutive
// bytes can be written or read in one cycle, each bank seeing one write.
module sfe_byte_fifo #(
  parameter int DEPTH = 32,
  parameter int LANES = 4,
  parameter int NW    = $clog2(LANES + 1),
  parameter int CW    = $clog2(DEPTH) + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic [NW-1:0]      push_n,
  input  logic [8*LANES-1:0] push_data,
  input  logic [NW-1:0]      pop_n,
  output logic [8*LANES-1:0] pop_data,
  output logic [CW-1:0]      count
);
  localparam int PW     = $clog2(DEPTH);
  localparam int BW     = $clog2(LANES);
  localparam int BDEPTH = DEPTH / LANES;

  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic [7:0]    bank_q [LANES];

  for (genvar b = 0; b < LANES; b++) begin : g_bank
    logic [7:0]    mem [BDEPTH];
    logic [BW-1:0] wk, rk;
    logic [PW-1:0] wa, ra;
    logic          we;

    assign wk = BW'(b) - wr_ptr[BW-1:0];
    assign wa = wr_ptr + PW'(wk);
    assign we = (NW'(wk) < push_n);
    assign rk = BW'(b) - rd_ptr[BW-1:0];
    assign ra = rd_ptr + PW'(rk);

    always_ff @(posedge clk) begin
      if (we) mem[wa[PW-1:BW]] <= push_data[8*(LANES-1-int'(wk)) +: 8];
    end

    assign bank_q[b] = mem[ra[PW-1:BW]];
  end

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      logic [BW-1:0] sel;
      sel = rd_ptr[BW-1:0] + BW'(k);
      pop_data[8*(LANES-1-k) +: 8] = bank_q[sel];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      wr_ptr <= wr_ptr + PW'(push_n);
      rd_ptr <= rd_ptr + PW'(pop_n);
      cnt    <= cnt + CW'(push_n) - CW'(pop_n);
    end
  end

  assign count = cnt;

  // R3: occupancy never exceeds capacity
  assert_fill_bound_R3: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));
  // R4: pointer distance agrees with the kept count
  assert_ptr_gap_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_ptr - rd_ptr) == cnt[PW-1:0]);
endmodule

// File: rtl/sfe_event_ctrl.sv
// Sticky event flags with write-one-to-clear and masked registered interrupt.
module sfe_event_ctrl #(
  parameter int FW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [FW-1:0] cond,
  input  logic          clr_we,
  input  logic [FW-1:0] clr_bits,
  input  logic [FW-1:0] mask,
  output logic [FW-1:0] flags,
  output logic          irq
);
  logic [FW-1:0] flags_d;

  assign flags_d = (flags & ~(clr_we ? clr_bits : '0)) | cond;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      irq   <= 1'b0;
    end else begin
      flags <= flags_d;
      irq   <= |(flags_d & mask);
    end
  end

  // R8: a cleared flag without a live condition reads zero afterwards
  assert_w1c_R8: assert property (@(posedge clk) disable iff (rst)
    clr_we |=> ((flags & $past(clr_bits) & ~$past(cond)) == '0));
  // R9: interrupt follows masked flags
  assert_irq_mask_R9: assert property (@(posedge clk) disable iff (rst)
    irq == |(flags & $past(mask)));
endmodule

// File: rtl/spi_fifo_event_unit.sv
module spi_fifo_event_unit #(
  parameter int DEPTH      = 32,
  parameter int ADDR_W     = 5,
  parameter int TX_THR_RST = 4,
  parameter int RX_THR_RST = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              sh_tx_valid,
  output logic [7:0]        sh_tx_data,
  input  logic              sh_tx_take,
  input  logic              sh_rx_push,
  input  logic [7:0]        sh_rx_data,
  input  logic              sh_done,
  output logic              irq
);
  import spi_fev_pkg::*;

  localparam int LANES = 4;
  localparam int NW    = $clog2(LANES + 1);
  localparam int CW    = $clog2(DEPTH) + 1;

  // mode state
  logic          mode_en, mode_loop;
  logic [CW-1:0] tx_thr, rx_thr;
  logic [15:0]   mask_q;

  // FIFO wiring
  logic [CW-1:0]      tx_cnt, rx_cnt, tx_free;
  logic [NW-1:0]      tx_push_n, tx_pop_n, rx_push_n, rx_pop_n;
  logic [8*LANES-1:0] tx_push_data, tx_pop_data, rx_push_data, rx_pop_data;
  logic [2:0]         nbytes;
  logic               sel_mode, sel_evt, sel_mask, sel_txd, sel_rxd;
  logic               tx_push_ok, rx_pop_ok, lb_move, ext_push;
  logic [7:0]         tx_head;
  logic [31:0]        rx_val, mode_word, evt_word;
  logic [15:0]        cond, flags;

  assign sel_mode = (bus_addr == ADDR_W'(OFS_MODE));
  assign sel_evt  = (bus_addr == ADDR_W'(OFS_EVT));
  assign sel_mask = (bus_addr == ADDR_W'(OFS_MASK));
  assign sel_txd  = (bus_addr == ADDR_W'(OFS_TXD));
  assign sel_rxd  = (bus_addr == ADDR_W'(OFS_RXD));
  assign nbytes   = acc_bytes(bus_size);
  assign tx_free  = CW'(DEPTH) - tx_cnt;

  // register-side transmit push, whole access or nothing
  assign tx_push_ok   = bus_wr && sel_txd && mode_en && (tx_free >= CW'(nbytes));
  assign tx_push_n    = tx_push_ok ? NW'(nbytes) : '0;
  assign tx_push_data = bus_wdata << (8 * (4 - int'(nbytes)));

  // register-side receive pop, whole access or nothing
  assign rx_pop_ok = bus_rd && sel_rxd && (rx_cnt >= CW'(nbytes));
  assign rx_pop_n  = rx_pop_ok ? NW'(nbytes) : '0;
  assign rx_val    = rx_pop_ok ? (rx_pop_data >> (8 * (4 - int'(nbytes)))) : '0;

  // shifter side and loopback
  assign tx_head     = tx_pop_data[8*LANES-1 -: 8];
  assign lb_move     = mode_en && mode_loop && (tx_cnt != '0) && (rx_cnt < CW'(DEPTH));
  assign sh_tx_valid = mode_en && !mode_loop && (tx_cnt != '0);
  assign sh_tx_data  = tx_head;
  assign tx_pop_n    = (lb_move || (sh_tx_valid && sh_tx_take)) ? NW'(1) : '0;
  assign ext_push    = mode_en && !mode_loop && sh_rx_push && (rx_cnt < CW'(DEPTH));
  assign rx_push_n   = (lb_move || ext_push) ? NW'(1) : '0;
  assign rx_push_data = {(mode_loop ? tx_head : sh_rx_data), {(8*(LANES-1)){1'b0}}};

  sfe_byte_fifo #(.DEPTH(DEPTH), .LANES(LANES)) u_txq (
    .clk(clk), .rst(rst), .clear(!mode_en),
    .push_n(tx_push_n), .push_data(tx_push_data),
    .pop_n(tx_pop_n), .pop_data(tx_pop_data), .count(tx_cnt));

  sfe_byte_fifo #(.DEPTH(DEPTH), .LANES(LANES)) u_rxq (
    .clk(clk), .rst(rst), .clear(!mode_en),
    .push_n(rx_push_n), .push_data(rx_push_data),
    .pop_n(rx_pop_n), .pop_data(rx_pop_data), .count(rx_cnt));

  // event conditions
  always_comb begin
    cond          = '0;
    cond[FLG_TXE] = (tx_cnt == '0);
    cond[FLG_DON] = sh_done;
    cond[FLG_RXT] = (rx_cnt > rx_thr);
    cond[FLG_RXF] = (rx_cnt == CW'(DEPTH));
    cond[FLG_TXT] = (tx_free > tx_thr);
    cond[FLG_RNE] = (rx_cnt != '0);
    cond[FLG_TNF] = (tx_free != '0);
  end

  sfe_event_ctrl #(.FW(16)) u_evt (
    .clk(clk), .rst(rst), .cond(cond),
    .clr_we(bus_wr && sel_evt), .clr_bits(bus_wdata[15:0]),
    .mask(mask_q), .flags(flags), .irq(irq));

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_en   <= 1'b0;
      mode_loop <= 1'b0;
      tx_thr    <= CW'(TX_THR_RST);
      rx_thr    <= CW'(RX_THR_RST);
      mask_q    <= '0;
    end else if (bus_wr) begin
      if (sel_mode) begin
        mode_en   <= bus_wdata[31];
        mode_loop <= bus_wdata[30];
        tx_thr    <= bus_wdata[8 +: CW];
        rx_thr    <= bus_wdata[0 +: CW];
      end
      if (sel_mask) mask_q <= bus_wdata[15:0] & FLG_VALID;
    end
  end

  always_comb begin
    mode_word         = '0;
    mode_word[31]     = mode_en;
    mode_word[30]     = mode_loop;
    mode_word[8 +: CW] = tx_thr;
    mode_word[0 +: CW] = rx_thr;
    evt_word          = '0;
    evt_word[24 +: CW] = rx_cnt;
    evt_word[16 +: CW] = tx_free;
    evt_word[15:0]    = flags;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (sel_mode)      bus_rdata <= mode_word;
      else if (sel_evt)  bus_rdata <= evt_word;
      else if (sel_mask) bus_rdata <= {16'h0000, mask_q};
      else if (sel_rxd)  bus_rdata <= rx_val;
      else               bus_rdata <= '0;
    end
  end

  // R3: an oversize or disabled transmit write never reduces free space
  assert_tx_drop_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && sel_txd && (tx_free < CW'(nbytes))) |=> (tx_free >= $past(tx_free)));
  // R5: receive occupancy stays within capacity
  assert_rx_bound_R5: assert property (@(posedge clk) disable iff (rst)
    rx_cnt <= CW'(DEPTH));
  // R11: shifter handshake is idle in loopback
  assert_loop_idle_R11: assert property (@(posedge clk) disable iff (rst)
    mode_loop |-> !sh_tx_valid);
  // R12: disabled block holds both FIFOs empty
  assert_flush_R12: assert property (@(posedge clk) disable iff (rst)
    !mode_en |=> (tx_cnt == '0) && (rx_cnt == '0));
endmodule

// File: tb/test_spi_fifo_event_unit.sv
`timescale 1ns/1ps
module test_spi_fifo_event_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [1:0]  bus_size = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sh_tx_valid;
  logic [7:0]  sh_tx_data;
  logic        sh_tx_take = 1'b0, sh_rx_push = 1'b0, sh_done = 1'b0;
  logic [7:0]  sh_rx_data = '0;
  logic        irq;

  int n_tests = 0, n_fail = 0;
  bit finished = 1'b0;
  byte unsigned txq[$], rxq[$];
  int txthr_m = 4, rxthr_m = 15;

  always #2 clk = ~clk;

  spi_fifo_event_unit i_spi_fifo_event_unit (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sh_tx_valid(sh_tx_valid), .sh_tx_data(sh_tx_data), .sh_tx_take(sh_tx_take),
    .sh_rx_push(sh_rx_push), .sh_rx_data(sh_rx_data), .sh_done(sh_done), .irq(irq));

  function automatic int nb(input int code);
    return (code == 0) ? 1 : (code == 1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] exp_evt(input int fr, input int rc, input int tt, input int rt);
    logic [31:0] w;
    w = (32'(rc) << 24) | (32'(fr) << 16);
    if (fr == 32) w[15] = 1'b1;
    if (rc > rt)  w[13] = 1'b1;
    if (rc == 32) w[12] = 1'b1;
    if (fr > tt)  w[11] = 1'b1;
    if (rc > 0)   w[9]  = 1'b1;
    if (fr > 0)   w[8]  = 1'b1;
    return w;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input int sz, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_size = 2'(sz); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input int sz, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a; bus_size = 2'(sz);
    @(posedge clk); #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // R3: model push with drop when space is short
  task automatic push_tx(input int sz, input logic [31:0] d);
    int n;
    logic [31:0] v;
    n = nb(sz);
    wr(5'h10, sz, d);
    if (32 - txq.size() >= n)
      for (int k = n - 1; k >= 0; k--) txq.push_back(d[8*k +: 8]);
    rd(5'h04, 2, v);
    check(v[21:16] == 6'(32 - txq.size()), "R3 tx free count", 32'(v[21:16]), 32'(32 - txq.size()));
  endtask

  // R4: model pop, zero on underfill
  task automatic pop_rx(input int sz);
    int n;
    logic [31:0] v, e;
    n = nb(sz);
    e = '0;
    if (rxq.size() >= n)
      for (int k = 0; k < n; k++) e = (e << 8) | 32'(rxq.pop_front());
    rd(5'h14, sz, v);
    check(v == e, "R4 rx read data", v, e);
  endtask

  task automatic shift_in(input logic [7:0] b);
    sh_rx_push = 1'b1; sh_rx_data = b;
    @(negedge clk);
    sh_rx_push = 1'b0;
    if (rxq.size() < 32) rxq.push_back(b);
  endtask

  // R5: shifter drains transmit bytes in order
  task automatic drain_tx();
    int guard;
    guard = 0;
    sh_tx_take = 1'b1;
    while (txq.size() > 0 && guard < 200) begin
      if (sh_tx_valid) begin
        check(sh_tx_data == txq[0], "R5 tx byte order", 32'(sh_tx_data), 32'(txq[0]));
        void'(txq.pop_front());
      end
      @(negedge clk);
      guard++;
    end
    sh_tx_take = 1'b0;
    check(!sh_tx_valid, "R5 tx valid low when empty", 32'(sh_tx_valid), 32'd0);
  endtask

  // R8, R10, R6: clear all flags, then only live conditions remain
  task automatic evt_clean(input string tag);
    logic [31:0] v, e;
    wr(5'h04, 2, 32'hFFFF_FFFF);
    idle(3);
    rd(5'h04, 2, v);
    e = exp_evt(32 - txq.size(), rxq.size(), txthr_m, rxthr_m);
    check(v == e, tag, v, e);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int sz;
    void'($urandom(32'h5EED));
    idle(3);
    rst = 1'b0;
    idle(1);

    // R1 reset state
    rd(5'h00, 2, v);
    check(v == 32'h0000_040F, "R1 mode reset", v, 32'h0000_040F);
    check(irq == 1'b0, "R1 irq reset", 32'(irq), 32'd0);
    idle(2);
    rd(5'h04, 2, v);
    check(v == exp_evt(32, 0, 4, 15), "R1 R6 events after reset", v, exp_evt(32, 0, 4, 15));

    // R12 disabled: write dropped
    wr(5'h10, 2, 32'h1122_3344);
    rd(5'h04, 2, v);
    check(v[21:16] == 6'd32, "R12 write while disabled dropped", 32'(v[21:16]), 32'd32);

    wr(5'h00, 2, 32'h8000_040F);
    rd(5'h00, 2, v);
    check(v == 32'h8000_040F, "R2 mode readback", v, 32'h8000_040F);

    // R3 random mixed-size transmit writes, then R5 drain
    for (int i = 0; i < 20; i++) begin
      sz = int'($urandom_range(0, 2));
      push_tx(sz, $urandom());
    end
    drain_tx();
    for (int i = 0; i < 14; i++) begin
      sz = int'($urandom_range(0, 2));
      push_tx(sz, $urandom());
    end
    drain_tx();

    // R3 fill to full, then a byte write is dropped
    while (32 - txq.size() >= 4) push_tx(2, $urandom());
    while (txq.size() < 32) push_tx(0, $urandom());
    push_tx(0, 32'h0000_00EE);
    push_tx(1, 32'h0000_BEEF);
    drain_tx();

    // R5 receive pushes, overflow bytes lost
    for (int i = 0; i < 36; i++) shift_in(8'($urandom()));
    rd(5'h04, 2, v);
    check(v[29:24] == 6'd32, "R5 rx count saturates", 32'(v[29:24]), 32'd32);
    evt_clean("R6 R7 events with full rx");
    while (rxq.size() > 0) pop_rx(int'($urandom_range(0, 2)));
    pop_rx(0);
    pop_rx(2);
    for (int i = 0; i < 3; i++) shift_in(8'($urandom()));
    pop_rx(2);
    pop_rx(1);
    pop_rx(0);

    // R10 receive threshold boundary
    wr(5'h00, 2, 32'h8000_0403);
    rxthr_m = 3;
    for (int i = 0; i < 3; i++) shift_in(8'(8'hA0 + i));
    evt_clean("R10 rx count equal to threshold");
    shift_in(8'hA3);
    evt_clean("R10 rx count above threshold");
    pop_rx(2);

    // R10 transmit threshold boundary
    for (int i = 0; i < 6; i++) push_tx(2, $urandom());
    push_tx(1, $urandom());
    push_tx(0, $urandom());
    evt_clean("R10 tx free above threshold");
    push_tx(0, $urandom());
    evt_clean("R10 tx free equal to threshold");
    drain_tx();
    evt_clean("R8 clean events after drain");

    // R7 R8 done flag
    sh_done = 1'b1; @(negedge clk); sh_done = 1'b0;
    idle(1);
    rd(5'h04, 2, v);
    check(v[14] == 1'b1, "R7 done flag set", 32'(v[14]), 32'd1);
    wr(5'h04, 2, 32'h0000_4000);
    idle(2);
    rd(5'h04, 2, v);
    check(v[14] == 1'b0, "R8 done flag cleared", 32'(v[14]), 32'd0);

    // R9 masked interrupt and sticky flag
    wr(5'h04, 2, 32'hFFFF_FFFF);
    wr(5'h08, 2, 32'h0000_0200);
    idle(3);
    check(irq == 1'b0, "R9 irq low with empty rx", 32'(irq), 32'd0);
    wr(5'h08, 2, 32'h0000_8000);
    idle(3);
    check(irq == 1'b1, "R9 irq from tx empty", 32'(irq), 32'd1);
    wr(5'h08, 2, 32'h0000_0200);
    idle(3);
    check(irq == 1'b0, "R9 irq masked off", 32'(irq), 32'd0);
    shift_in(8'h5A);
    idle(3);
    check(irq == 1'b1, "R9 irq on rx not empty", 32'(irq), 32'd1);
    pop_rx(0);
    idle(3);
    check(irq == 1'b1, "R7 flag sticky after condition ends", 32'(irq), 32'd1);
    wr(5'h04, 2, 32'h0000_0200);
    idle(3);
    check(irq == 1'b0, "R8 R9 irq clears after w1c", 32'(irq), 32'd0);
    wr(5'h08, 2, 32'h0000_0000);

    // R11 loopback
    wr(5'h00, 2, 32'hC000_0403);
    push_tx(2, 32'hA1B2_C3D4);
    check(sh_tx_valid == 1'b0, "R11 shifter idle in loopback", 32'(sh_tx_valid), 32'd0);
    idle(8);
    while (txq.size() > 0) rxq.push_back(txq.pop_front());
    rd(5'h04, 2, v);
    check(v[21:16] == 6'd32 && v[29:24] == 6'd4, "R11 loopback counts", v & 32'h3F3F_0000, 32'h0420_0000);
    pop_rx(2);

    // R12 disable flushes
    wr(5'h00, 2, 32'h8000_0403);
    push_tx(1, 32'h0000_1234);
    shift_in(8'h77);
    shift_in(8'h78);
    wr(5'h00, 2, 32'h0000_0403);
    txq.delete();
    rxq.delete();
    idle(2);
    rd(5'h04, 2, v);
    check(v[21:16] == 6'd32 && v[29:24] == 6'd0, "R12 flush on disable", v & 32'h3F3F_0000, 32'h0020_0000);
    wr(5'h00, 2, 32'h8000_0403);
    pop_rx(0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule